// File: doc/BRIEF.md
# Serial Configuration Register Master

This block is the master side of a three-wire serial port. A radio transceiver uses that port to accept its configuration. Each transfer reads or writes one 8-bit register at a 7-bit address. The transfer is carried in a 16-bit frame: seven address bits, then one direction bit, then eight data bits, all sent most significant bit first.

The master owns three lines: a select strobe, a serial clock and a serial output. It samples one serial input. A host starts a single transfer by raising a request while the master shows it is ready. Read data is presented once the master is ready again.

A second start input runs a bulk load. The bulk load writes every register from address 0 up to a parameterised last address (39 by default), in rising order. It takes each byte from a table source outside the block, which the master indexes through an address output.

The length of each serial clock phase is set at run time by a divider input.

Top module: `cfgser_master`

## Requirements
- R1: After reset the select, serial clock and serial output are low, ready is high and the read result is 0.
- R2: Every transfer raises select, gives exactly 16 serial clock pulses and then drops select while the serial clock is low. The serial clock is never high while select is low.
- R3: A write sends the address MSB first, then a direction bit of 1, then the data MSB first. The serial output changes only while the serial clock is low and holds steady through each high phase.
- R4: A read sends the address MSB first, then a direction bit of 0. It then samples the serial input in the last system cycle of each of the eight following high phases, MSB first. The assembled byte appears on the read result when ready returns high.
- R5: A request is taken only on a cycle where ready is high. Ready stays low for the whole transfer, which lasts 33 × (divider + 1) system cycles from the accepting edge.
- R6: Every serial clock phase, high or low, lasts divider + 1 system cycles.
- R7: A bulk load writes addresses 0 through the last address in rising order. Each write carries the byte the table source returns for that address. Select drops for one phase between frames, and ready stays low until the last frame ends.
- R8: If bulk start and a single request are both present on a ready cycle, the bulk load wins. A request still held when ready returns is then served.
- R9: Bulk start and single requests that arrive while a transfer is running are ignored. They start no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_i | input | 8 | Phase length minus one, in system cycles |
| req_valid_i | input | 1 | Single-transfer request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 7 | Register address |
| req_wdata_i | input | 8 | Write data |
| bulk_start_i | input | 1 | Start a bulk load from the table |
| ready_o | output | 1 | High when idle and able to accept |
| rd_data_o | output | 8 | Result of the latest read |
| tbl_addr_o | output | 7 | Table index for the bulk load |
| tbl_data_i | input | 8 | Table byte for tbl_addr_o |
| sel_o | output | 1 | Serial select strobe |
| sclk_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data to the device |
| sdi_i | input | 1 | Serial data from the device |

## Verification
A bulk start and a single request can arrive in the same ready cycle. The bench provokes this by raising both on one edge and then holding only the request. The outcome is judged from a device model on the serial lines: it must see the whole bulk sequence of addresses and table bytes, followed by exactly one extra frame carrying the held write.

// File: rtl/cfgser_pkg.sv
package cfgser_pkg;

    localparam int ADDR_W  = 7;
    localparam int DATA_W  = 8;
    localparam int FRAME_W = ADDR_W + 1 + DATA_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_TAIL,
        ST_GAP
    } seq_state_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic [DATA_W-1:0] data;
    } frame_t;

    // Build the shift image of one frame; a read carries zeros in its data slot.
    function automatic frame_t make_frame(input logic [ADDR_W-1:0] addr,
                                          input logic              wr,
                                          input logic [DATA_W-1:0] data);
        frame_t f;
        f.addr = addr;
        f.wr   = wr;
        f.data = wr ? data : '0;
        return f;
    endfunction

endpackage

// File: rtl/cfgser_phase_timer.sv
module cfgser_phase_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DIV_W-1:0] div_i,
    output logic             phase_end
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= div_i;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign phase_end = (cnt == '0);

    // R6: a freshly loaded count starts from the divider value.
    assert_load_value_R6: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(div_i)));

endmodule

// File: rtl/cfgser_shifter.sv
module cfgser_shifter
    import cfgser_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  frame_t            frame_in,
    input  logic              shift,
    input  logic              capture,
    input  logic              sdi,
    output logic              msb,
    output logic [DATA_W-1:0] rx_byte
);
    logic [FRAME_W-1:0] shreg;
    logic [DATA_W-1:0]  rx;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
        end else if (load) begin
            shreg <= frame_in;
        end else if (shift) begin
            shreg <= {shreg[FRAME_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx <= '0;
        end else if (capture) begin
            rx <= {rx[DATA_W-2:0], sdi};
        end
    end

    assign msb     = shreg[FRAME_W-1];
    assign rx_byte = rx;

    // R4: received bits enter at the LSB end and move up by one place.
    assert_rx_shift_R4: assert property (@(posedge clk) disable iff (rst)
        capture |=> (rx[DATA_W-1:1] == $past(rx[DATA_W-2:0])));

endmodule

// File: rtl/cfgser_bulk_seq.sv
module cfgser_bulk_seq #(
    parameter int ADDR_W    = 7,
    parameter int BULK_LAST = 39
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    input  logic              clear,
    output logic [ADDR_W-1:0] addr,
    output logic              at_last
);
    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(BULK_LAST);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            addr <= '0;
        end else if (advance) begin
            addr <= addr + 1'b1;
        end
    end

    assign at_last = (addr == LAST_A);

    // R7: the table index only steps up by one or returns to zero.
    assert_bulk_order_R7: assert property (@(posedge clk) disable iff (rst)
        (addr != $past(addr)) |-> ((addr == $past(addr) + 1'b1) || (addr == '0)));

    // R7: the index never runs past the last bulk address.
    assert_bulk_bound_R7: assert property (@(posedge clk) disable iff (rst)
        addr <= LAST_A);

endmodule

// File: rtl/cfgser_master.sv
module cfgser_master
    import cfgser_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int BULK_LAST = 39
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  div_i,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic              bulk_start_i,
    output logic              ready_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [ADDR_W-1:0] tbl_addr_o,
    input  logic [DATA_W-1:0] tbl_data_i,
    output logic              sel_o,
    output logic              sclk_o,
    output logic              sdo_o,
    input  logic              sdi_i
);
    localparam int BIT_W = $clog2(FRAME_W);
    localparam logic [BIT_W-1:0] LAST_BIT   = BIT_W'(FRAME_W - 1);
    localparam logic [BIT_W-1:0] FIRST_DATA = BIT_W'(ADDR_W + 1);

    seq_state_t       state;
    logic [BIT_W-1:0] bit_idx;
    logic             bulk_mode;
    logic             wr_mode;

    logic   phase_done;
    logic   start_bulk, start_single;
    logic   tmr_load, load_frame, do_shift, do_capture;
    logic   bulk_adv, bulk_clr, bulk_last, tail_done;
    frame_t frame_in;
    logic   msb;
    logic [ADDR_W-1:0] bulk_addr;

    // Bulk start has priority over a single request on the same ready cycle.
    assign start_bulk   = (state == ST_IDLE) && bulk_start_i;
    assign start_single = (state == ST_IDLE) && req_valid_i && !bulk_start_i;

    always_comb begin
        tail_done  = (state == ST_TAIL) && phase_done;
        tmr_load   = start_bulk || start_single || ((state != ST_IDLE) && phase_done);
        load_frame = start_bulk || start_single || ((state == ST_GAP) && phase_done);
        do_shift   = (state == ST_HIGH) && phase_done;
        do_capture = do_shift && !wr_mode && (bit_idx >= FIRST_DATA);
        bulk_adv   = tail_done && bulk_mode && !bulk_last;
        bulk_clr   = tail_done && !(bulk_mode && !bulk_last);
        if (start_single) begin
            frame_in = make_frame(req_addr_i, req_write_i, req_wdata_i);
        end else begin
            frame_in = make_frame(bulk_addr, 1'b1, tbl_data_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            bit_idx   <= '0;
            bulk_mode <= 1'b0;
            wr_mode   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    bit_idx <= '0;
                    if (start_bulk) begin
                        state     <= ST_LOW;
                        bulk_mode <= 1'b1;
                        wr_mode   <= 1'b1;
                    end else if (start_single) begin
                        state     <= ST_LOW;
                        bulk_mode <= 1'b0;
                        wr_mode   <= req_write_i;
                    end
                end
                ST_LOW: begin
                    if (phase_done) state <= ST_HIGH;
                end
                ST_HIGH: begin
                    if (phase_done) begin
                        if (bit_idx == LAST_BIT) begin
                            state   <= ST_TAIL;
                            bit_idx <= '0;
                        end else begin
                            state   <= ST_LOW;
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end
                end
                ST_TAIL: begin
                    if (phase_done) begin
                        if (bulk_mode && !bulk_last) begin
                            state <= ST_GAP;
                        end else begin
                            state     <= ST_IDLE;
                            bulk_mode <= 1'b0;
                        end
                    end
                end
                ST_GAP: begin
                    if (phase_done) state <= ST_LOW;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    cfgser_phase_timer #(.DIV_W(DIV_W)) i_timer (
        .clk       (clk),
        .rst       (rst),
        .load      (tmr_load),
        .div_i     (div_i),
        .phase_end (phase_done)
    );

    cfgser_shifter i_shifter (
        .clk      (clk),
        .rst      (rst),
        .load     (load_frame),
        .frame_in (frame_in),
        .shift    (do_shift),
        .capture  (do_capture),
        .sdi      (sdi_i),
        .msb      (msb),
        .rx_byte  (rd_data_o)
    );

    cfgser_bulk_seq #(.ADDR_W(ADDR_W), .BULK_LAST(BULK_LAST)) i_bulk (
        .clk     (clk),
        .rst     (rst),
        .advance (bulk_adv),
        .clear   (bulk_clr),
        .addr    (bulk_addr),
        .at_last (bulk_last)
    );

    assign ready_o    = (state == ST_IDLE);
    assign sel_o      = (state == ST_LOW) || (state == ST_HIGH) || (state == ST_TAIL);
    assign sclk_o     = (state == ST_HIGH);
    assign sdo_o      = msb;
    assign tbl_addr_o = bulk_addr;

    // R2: clock pulses only inside a selected frame.
    assert_clk_in_frame_R2: assert property (@(posedge clk) disable iff (rst)
        sclk_o |-> sel_o);

    // R2: select is released only with the clock low.
    assert_sel_drop_low_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(sel_o) |-> !$past(sclk_o));

    // R3: serial data holds steady while the clock stays high.
    assert_sdo_stable_high_R3: assert property (@(posedge clk) disable iff (rst)
        (sclk_o && $past(sclk_o)) |-> $stable(sdo_o));

    // R5: an accepted request drops ready on the next cycle.
    assert_accept_busy_R5: assert property (@(posedge clk) disable iff (rst)
        (ready_o && (req_valid_i || bulk_start_i)) |=> !ready_o);

endmodule

// File: tb/test_cfgser_master.sv
module test_cfgser_master;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] div_i;
    logic       req_valid_i, req_write_i, bulk_start_i;
    logic [6:0] req_addr_i;
    logic [7:0] req_wdata_i;
    logic       ready_o;
    logic [7:0] rd_data_o;
    logic [6:0] tbl_addr_o;
    logic [7:0] tbl_data_i;
    logic       sel_o, sclk_o, sdo_o, sdi_i;

    always #2 clk = ~clk;

    cfgser_master i_cfgser_master (
        .clk(clk), .rst(rst), .div_i(div_i),
        .req_valid_i(req_valid_i), .req_write_i(req_write_i),
        .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
        .bulk_start_i(bulk_start_i), .ready_o(ready_o), .rd_data_o(rd_data_o),
        .tbl_addr_o(tbl_addr_o), .tbl_data_i(tbl_data_i),
        .sel_o(sel_o), .sclk_o(sclk_o), .sdo_o(sdo_o), .sdi_i(sdi_i)
    );

    // Table source: an arbitrary function of the index.
    function automatic logic [7:0] tbl_fn(input logic [6:0] a);
        return {a, 1'b1} ^ 8'h5A;
    endfunction
    assign tbl_data_i = tbl_fn(tbl_addr_o);

    // ---------------- device model on the serial lines ----------------
    logic [7:0] mem [128];
    int         scnt = 0;
    logic [6:0] s_addr = '0;
    logic       s_dir  = 1'b1;
    logic [7:0] s_data = '0;
    int         last_cnt = 0;
    logic       sclk_at_drop = 1'b0;
    int         nframes = 0;
    int         nwr = 0;
    logic [6:0] log_addr [256];
    logic [7:0] log_data [256];

    initial for (int i = 0; i < 128; i++) mem[i] = ~8'(i);

    always @(posedge sel_o) scnt = 0;
    always @(posedge sclk_o) begin
        if (scnt < 7) s_addr = {s_addr[5:0], sdo_o};
        else if (scnt == 7) s_dir = sdo_o;
        else s_data = {s_data[6:0], sdo_o};
        scnt = scnt + 1;
    end
    always @(negedge sel_o) begin
        nframes = nframes + 1;
        last_cnt = scnt;
        sclk_at_drop = sclk_o;
        if (s_dir && scnt == 16) begin
            mem[s_addr] = s_data;
            if (nwr < 256) begin
                log_addr[nwr] = s_addr;
                log_data[nwr] = s_data;
            end
            nwr = nwr + 1;
        end
    end
    assign sdi_i = (!s_dir && scnt >= 9 && scnt <= 16) ? mem[s_addr][16 - scnt] : 1'b0;

    // Phase length measurement while selected.
    int   cur_len = 0, last_hi = 0, last_lo = 0;
    logic prev_sclk = 1'b0;
    always @(negedge clk) begin
        if (!sel_o) begin
            cur_len = 0;
            prev_sclk = 1'b0;
        end else if (sclk_o == prev_sclk) begin
            cur_len = cur_len + 1;
        end else begin
            if (prev_sclk) last_hi = cur_len; else last_lo = cur_len;
            cur_len = 1;
            prev_sclk = sclk_o;
        end
    end

    // ---------------- bookkeeping ----------------
    int  vectors = 0, fails = 0;
    bit  done = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    // Issue one single transfer, return busy cycle count.
    task automatic single(input bit wr, input logic [6:0] a, input logic [7:0] d, output int busy);
        @(negedge clk);
        req_valid_i = 1'b1; req_write_i = wr; req_addr_i = a; req_wdata_i = d;
        @(negedge clk);
        req_valid_i = 1'b0;
        busy = 0;
        while (!ready_o) begin
            busy++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        check(sel_o == 0 && sclk_o == 0 && sdo_o == 0, "R1 lines", {sel_o, sclk_o, sdo_o}, 0);
        check(ready_o == 1, "R1 ready", ready_o, 1);
        check(rd_data_o == 0, "R1 rd_data", rd_data_o, 0);
    endtask

    task automatic t_write(input logic [6:0] a, input logic [7:0] d);
        int busy;
        int nw0 = nwr;
        single(1'b1, a, d, busy);
        check(nwr == nw0 + 1, "R3 write seen", nwr - nw0, 1);
        check(s_addr == a, "R3 address", s_addr, a);
        check(s_dir == 1'b1, "R3 direction bit", s_dir, 1);
        check(s_data == d, "R3 data", s_data, d);
        check(last_cnt == 16, "R2 pulse count", last_cnt, 16);
        check(sclk_at_drop == 1'b0, "R2 clock low at release", sclk_at_drop, 0);
        check(busy == 33 * (div_i + 1), "R5 busy length", busy, 33 * (div_i + 1));
    endtask

    task automatic t_read(input logic [6:0] a);
        int busy;
        logic [7:0] exp = mem[a];
        single(1'b0, a, 8'hFF, busy);
        check(s_addr == a, "R4 address", s_addr, a);
        check(s_dir == 1'b0, "R4 direction bit", s_dir, 0);
        check(last_cnt == 16, "R2 pulse count read", last_cnt, 16);
        check(rd_data_o == exp, "R4 read data", rd_data_o, exp);
        check(busy == 33 * (div_i + 1), "R5 busy length read", busy, 33 * (div_i + 1));
    endtask

    task automatic t_divider(input logic [7:0] dv);
        div_i = dv;
        t_write(7'h11, 8'h96);
        check(last_hi == dv + 1, "R6 high phase", last_hi, dv + 1);
        check(last_lo == dv + 1, "R6 low phase", last_lo, dv + 1);
    endtask

    task automatic t_bulk();
        int nw0 = nwr;
        int nf0 = nframes;
        @(negedge clk);
        bulk_start_i = 1'b1;
        @(negedge clk);
        bulk_start_i = 1'b0;
        check(ready_o == 1'b0, "R7 busy during bulk", ready_o, 0);
        while (!ready_o) @(negedge clk);
        check(nwr - nw0 == 40, "R7 write count", nwr - nw0, 40);
        check(nframes - nf0 == 40, "R7 frame count", nframes - nf0, 40);
        for (int i = 0; i < 40; i++) begin
            check(log_addr[nw0 + i] == 7'(i), "R7 order", log_addr[nw0 + i], i);
            check(log_data[nw0 + i] == tbl_fn(7'(i)), "R7 table byte",
                  log_data[nw0 + i], tbl_fn(7'(i)));
        end
    endtask

    task automatic t_collide();
        int nw0 = nwr;
        @(negedge clk);
        bulk_start_i = 1'b1;
        req_valid_i = 1'b1; req_write_i = 1'b1; req_addr_i = 7'h50; req_wdata_i = 8'h3E;
        @(negedge clk);
        bulk_start_i = 1'b0;
        while (!ready_o) @(negedge clk);
        @(negedge clk);
        req_valid_i = 1'b0;
        while (!ready_o) @(negedge clk);
        check(nwr - nw0 == 41, "R8 frames after collision", nwr - nw0, 41);
        check(log_addr[nw0] == 7'h00, "R8 bulk served first", log_addr[nw0], 0);
        check(log_addr[nw0 + 40] == 7'h50, "R8 held request last", log_addr[nw0 + 40], 'h50);
        check(log_data[nw0 + 40] == 8'h3E, "R8 held request data", log_data[nw0 + 40], 'h3E);
    endtask

    task automatic t_ignore();
        int nw0 = nwr;
        logic [7:0] keep = mem[7'h66];
        @(negedge clk);
        req_valid_i = 1'b1; req_write_i = 1'b1; req_addr_i = 7'h22; req_wdata_i = 8'h81;
        @(negedge clk);
        req_valid_i = 1'b0;
        repeat (5) @(negedge clk);
        bulk_start_i = 1'b1;
        req_valid_i = 1'b1; req_addr_i = 7'h66; req_wdata_i = 8'h00;
        @(negedge clk);
        bulk_start_i = 1'b0;
        req_valid_i = 1'b0;
        while (!ready_o) @(negedge clk);
        repeat (3) @(negedge clk);
        check(nwr - nw0 == 1, "R9 only one frame", nwr - nw0, 1);
        check(mem[7'h66] == keep, "R9 busy request dropped", mem[7'h66], keep);
        check(ready_o == 1'b1, "R9 idle after", ready_o, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        finish_run();
    end

    initial begin
        rst = 1'b1; div_i = 8'd1;
        req_valid_i = 0; req_write_i = 0; req_addr_i = '0; req_wdata_i = '0; bulk_start_i = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write(7'h2A, 8'hC3);
        t_write(7'h7F, 8'h01);
        t_read(7'h13);
        t_write(7'h3C, 8'hA5);
        t_read(7'h3C);
        t_read(7'h00);
        t_divider(8'd0);
        t_divider(8'd3);
        div_i = 8'd1;
        t_read(7'h7F);
        t_bulk();
        t_collide();
        t_ignore();
        finish_run();
    end
endmodule